// File: doc/BRIEF.md
# Time-Slotted Pseudo-Dual-Port Register File

This block makes one single-port storage array (1024 entries of 80 bits by default) look like a memory with two independent ports. It runs on a fast clock at twice the bus rate. A phase input splits each bus cycle into two fixed slots. In the slot where the phase is 0, only the system-bus side reaches the array. In the slot where the phase is 1, only the I/O side reaches it. Because the slots are fixed, no arbitration logic is needed and neither side ever waits.

Each side has its own write enable, address, write data and read data. During its slot, a side either writes its data into the array or reads the addressed entry into a private output register. That register keeps its value until the same side reads again. The I/O side is used by a slower shared bus serving two channels. The system side follows the backplane every bus cycle. A monitor raises an error flag when the phase input fails to alternate between consecutive fast-clock edges.

Top module: `tsrf_top`

## Requirements
- R1: While `rst` is high, at every fast edge `bus_rdata` and `io_rdata` are cleared to zero and `phase_err` is cleared to 0.
- R2: At a fast edge with `phase`=0 and `bus_we`=1, the array entry at `bus_addr` takes the value `bus_wdata`.
- R3: At a fast edge with `phase`=1 and `io_we`=1, the array entry at `io_addr` takes the value `io_wdata`.
- R4: At a fast edge with `phase`=0 and `bus_we`=0, `bus_rdata` takes the contents of entry `bus_addr`. At a fast edge with `phase`=1 and `io_we`=0, `io_rdata` takes the contents of entry `io_addr`.
- R5: Each side's read-data output keeps its value at every edge other than its own read edge, including the edges where that side writes.
- R6: A system-side write in slot 0 is returned by an I/O-side read of the same address in slot 1 of the same bus cycle.
- R7: An I/O-side write in slot 1 is returned by a system-side read of the same address in slot 0 of the next bus cycle. If both sides write one address in the same bus cycle, the I/O value remains.
- R8: System-side inputs have no effect at `phase`=1 edges, and I/O-side inputs have no effect at `phase`=0 edges.
- R9: After an edge at which `phase` equals its value at the previous non-reset edge, `phase_err` is 1. After an edge at which `phase` changed, `phase_err` is 0.
- R10: The highest address (1023) and address 0 are stored and read back like any other entry, with all 80 data bits kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 1 | Slot indicator: 0 for the system slot, 1 for the I/O slot |
| bus_we | input | 1 | System-side write enable |
| bus_addr | input | 10 | System-side entry address |
| bus_wdata | input | 80 | System-side write data |
| bus_rdata | output | 80 | System-side read data, held between reads |
| io_we | input | 1 | I/O-side write enable |
| io_addr | input | 10 | I/O-side entry address |
| io_wdata | input | 80 | I/O-side write data |
| io_rdata | output | 80 | I/O-side read data, held between reads |
| phase_err | output | 1 | High after an edge where the phase did not alternate |

## Verification
The embedded properties check the following on every edge: the reset state of the outputs, the stability of each output between its own read edges, the rule that a phase repeat raises the error flag while a change clears it, and the same-cycle forwarding of a system write to an I/O read. The bench scenarios are the only place that shows the contents of stored data. This covers round trips through distant addresses and the last-writer rule when both sides write one entry. It also covers the fact that a write enable raised in the other side's slot leaves the array untouched, which can only be seen by reading the entry back later.

// File: rtl/tsrf_pkg.sv
package tsrf_pkg;

    localparam int DEF_DEPTH = 1024;
    localparam int DEF_WIDTH = 80;

    typedef enum logic {
        SLOT_SYS = 1'b0,
        SLOT_IO  = 1'b1
    } slot_e;

    function automatic slot_e slot_of(input logic ph);
        return ph ? SLOT_IO : SLOT_SYS;
    endfunction

    function automatic logic phase_alternated(input logic now_ph, input logic last_ph);
        return now_ph != last_ph;
    endfunction

endpackage

// File: rtl/tsrf_slot_mux.sv
module tsrf_slot_mux
    import tsrf_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 80
) (
    input  logic          phase,
    input  logic          sys_we,
    input  logic [AW-1:0] sys_addr,
    input  logic [DW-1:0] sys_wd,
    input  logic          io_we,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wd,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wd,
    output logic          ld_sys,
    output logic          ld_io
);
    slot_e slot;

    always_comb begin
        slot     = slot_of(phase);
        arr_we   = 1'b0;
        arr_addr = '0;
        arr_wd   = '0;
        ld_sys   = 1'b0;
        ld_io    = 1'b0;
        unique case (slot)
            SLOT_SYS: begin
                arr_we   = sys_we;
                arr_addr = sys_addr;
                arr_wd   = sys_wd;
                ld_sys   = ~sys_we;
            end
            SLOT_IO: begin
                arr_we   = io_we;
                arr_addr = io_addr;
                arr_wd   = io_wd;
                ld_io    = ~io_we;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tsrf_sp_array.sv
module tsrf_sp_array #(
    parameter int DEPTH = 1024,
    parameter int DW    = 80,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wd;
    end

    assign rd = cells[addr];
endmodule

// File: rtl/tsrf_rd_hold.sv
module tsrf_rd_hold #(
    parameter int DW = 80
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));
endmodule

// File: rtl/tsrf_phase_mon.sv
module tsrf_phase_mon
    import tsrf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase,
    output logic err
);
    logic ph_q;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= 1'b0;
            armed <= 1'b0;
            err   <= 1'b0;
        end else begin
            ph_q  <= phase;
            armed <= 1'b1;
            err   <= armed & ~phase_alternated(phase, ph_q);
        end
    end

    // R9
    phase_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(phase)) |=> err);

    // R9
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(phase)) |=> !err);
endmodule

// File: rtl/tsrf_top.sv
module tsrf_top
    import tsrf_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int DW    = DEF_WIDTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int NPORT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          phase,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          io_we,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          phase_err
);
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wd;
    logic [DW-1:0] arr_rd;
    logic          ld   [NPORT];
    logic [DW-1:0] hold [NPORT];

    tsrf_slot_mux #(.AW(AW), .DW(DW)) u_mux (
        .phase   (phase),
        .sys_we  (bus_we),
        .sys_addr(bus_addr),
        .sys_wd  (bus_wdata),
        .io_we   (io_we),
        .io_addr (io_addr),
        .io_wd   (io_wdata),
        .arr_we  (arr_we),
        .arr_addr(arr_addr),
        .arr_wd  (arr_wd),
        .ld_sys  (ld[0]),
        .ld_io   (ld[1])
    );

    tsrf_sp_array #(.DEPTH(DEPTH), .DW(DW)) u_arr (
        .clk (clk),
        .we  (arr_we),
        .addr(arr_addr),
        .wd  (arr_wd),
        .rd  (arr_rd)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        tsrf_rd_hold #(.DW(DW)) u_hold (
            .clk(clk),
            .rst(rst),
            .ld (ld[p]),
            .d  (arr_rd),
            .q  (hold[p])
        );
    end

    assign bus_rdata = hold[0];
    assign io_rdata  = hold[1];

    tsrf_phase_mon u_mon (
        .clk  (clk),
        .rst  (rst),
        .phase(phase),
        .err  (phase_err)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && io_rdata == '0 && !phase_err));

    // R6
    same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && phase && !$past(phase) && $past(bus_we) && !io_we
         && io_addr == $past(bus_addr))
        |=> io_rdata == $past(bus_wdata, 2));
endmodule

// File: tb/sim_tsrf_top.sv
module sim_tsrf_top;
    localparam int CLK_PER = 10;
    localparam int AW = 10;
    localparam int DW = 80;
    localparam int NV = 10;
    localparam logic [DW-1:0] ALL1 = 80'hFFFFFFFFFFFFFFFFFFFF;

    typedef struct packed {
        logic          bwe;
        logic [AW-1:0] ba;
        logic [DW-1:0] bwd;
        logic          iwe;
        logic [AW-1:0] ia;
        logic [DW-1:0] iwd;
        logic [DW-1:0] eb;
        logic [DW-1:0] ei;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 10'd5,    80'h1111, 1'b0, 10'd5,    80'h0,    80'h0,    80'h1111},
        '{1'b0, 10'd5,    80'h0,    1'b1, 10'd9,    80'h2222, 80'h1111, 80'h1111},
        '{1'b0, 10'd9,    80'h0,    1'b0, 10'd5,    80'h0,    80'h2222, 80'h1111},
        '{1'b1, 10'd9,    80'h3333, 1'b1, 10'd5,    80'h4444, 80'h2222, 80'h1111},
        '{1'b0, 10'd5,    80'h0,    1'b0, 10'd9,    80'h0,    80'h4444, 80'h3333},
        '{1'b1, 10'd1023, ALL1,     1'b0, 10'd1023, 80'h0,    80'h4444, ALL1},
        '{1'b0, 10'd1023, 80'h0,    1'b1, 10'd0,    80'h6666, ALL1,     ALL1},
        '{1'b0, 10'd0,    80'h0,    1'b0, 10'd1023, 80'h0,    80'h6666, ALL1},
        '{1'b1, 10'd7,    80'h7777, 1'b1, 10'd7,    80'h8888, 80'h6666, ALL1},
        '{1'b0, 10'd7,    80'h0,    1'b0, 10'd7,    80'h0,    80'h8888, 80'h8888}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          phase = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          io_we = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic [DW-1:0] io_wdata = '0;
    logic [DW-1:0] io_rdata;
    logic          phase_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    tsrf_top u0 (
        .clk(clk), .rst(rst), .phase(phase),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .phase_err(phase_err)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Caller is at a negedge; returns at the negedge after the slot-1 edge.
    task automatic run_cycle(input logic bwe, input logic [AW-1:0] ba, input logic [DW-1:0] bwd,
                             input logic iwe, input logic [AW-1:0] ia, input logic [DW-1:0] iwd);
        phase = 1'b0;
        bus_we = bwe; bus_addr = ba; bus_wdata = bwd;
        io_we = iwe;  io_addr = ia;  io_wdata = iwd;
        @(negedge clk);
        phase = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            phase = ~phase;
        end
        @(negedge clk);
        rst = 1'b0;
        // R1: outputs cleared by reset
        check("R1 bus_rdata", bus_rdata, '0);
        check("R1 io_rdata", io_rdata, '0);
        check("R1 phase_err", {79'd0, phase_err}, '0);

        // Vector table: R2 R3 R4 R5 R6 R7 R10, and R9 stays low while alternating
        for (int i = 0; i < NV; i++) begin
            run_cycle(VECS[i].bwe, VECS[i].ba, VECS[i].bwd, VECS[i].iwe, VECS[i].ia, VECS[i].iwd);
            check($sformatf("R2/R4/R5/R7/R10 bus row %0d", i), bus_rdata, VECS[i].eb);
            check($sformatf("R3/R4/R5/R6/R10 io row %0d", i), io_rdata, VECS[i].ei);
            check($sformatf("R9 no error row %0d", i), {79'd0, phase_err}, '0);
        end

        // R8: each side's write enable asserted only in the other side's slot
        phase = 1'b0;
        bus_we = 1'b0; bus_addr = 10'd5; bus_wdata = '0;
        io_we = 1'b1;  io_addr = 10'd9;  io_wdata = 80'hDEAD;
        @(negedge clk);
        phase = 1'b1;
        bus_we = 1'b1; bus_addr = 10'd5; bus_wdata = 80'hBEEF;
        io_we = 1'b0;  io_addr = 10'd9;
        @(negedge clk);
        check("R8 io write in slot 0 ignored", io_rdata, 80'h3333);
        check("R8 bus read in slot 0", bus_rdata, 80'h4444);
        run_cycle(1'b0, 10'd5, '0, 1'b0, 10'd5, '0);
        check("R8 bus write in slot 1 ignored (bus)", bus_rdata, 80'h4444);
        check("R8 bus write in slot 1 ignored (io)", io_rdata, 80'h4444);

        // R9: phase held at 1 for one extra edge
        io_we = 1'b0;
        phase = 1'b1;
        @(negedge clk);
        check("R9 repeat flagged", {79'd0, phase_err}, {79'd0, 1'b1});
        phase = 1'b0;
        bus_we = 1'b0;
        @(negedge clk);
        check("R9 cleared on toggle", {79'd0, phase_err}, '0);
        phase = 1'b0;
        @(negedge clk);
        check("R9 slot 0 repeat flagged", {79'd0, phase_err}, {79'd0, 1'b1});
        phase = 1'b1;
        @(negedge clk);
        check("R9 cleared again", {79'd0, phase_err}, '0);

        // R1: reset mid-run clears held data
        rst = 1'b1;
        phase = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R1 bus cleared mid-run", bus_rdata, '0);
        check("R1 io cleared mid-run", io_rdata, '0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule